// File: doc/BRIEF.md
# Core Rail Low-Power Mode Controller

This block decides when the core supply rail drops into its low-power state and when it comes back out. A processor drives a sleep request pin, and software controls two configuration bits. One bit allows the sleep request to be honoured at all. The other bit chooses whether sleep lowers the core voltage or switches the core rail off. Two wake sources, a push button and a hot-reset button, arrive as clean single-cycle pulses. Debouncing is done upstream.

The request pin is gated by the allow bit. Low-power mode starts only on a rising edge of that gated signal. Four conditions end it: the gated signal falling, either wake pulse, or a wake pulse arriving in the same cycle as an entry edge. After an exit, the block re-enters only after a fresh rising edge. That edge comes from toggling the request pin, or from toggling the allow bit while the request pin stays high.

While the mode is active, the voltage select output carries the low-power preset, or the core-off output is raised instead. The normal voltage setting is captured while the block is awake and frozen during low-power mode. On exit, the core therefore returns to the setting it had when it went to sleep.

Top module: `lpm_ctrl`

## Requirements
- R1: Within three clock cycles after rst_n is released, with sleep_req_i low, lp_active_o and core_off_o are 0 and core_vsel_o equals vsel_norm_i.
- R2: lp_active_o goes to 1 at the clock edge that first samples sleep_req_i AND sleep_allow_i high after a cycle in which that AND was low.
- R3: While sleep_allow_i is 0, sleep_req_i has no effect: lp_active_o is 0 from the next cycle on.
- R4: Sampling sleep_req_i low forces lp_active_o to 0 at the next cycle.
- R5: Sampling sleep_allow_i low forces lp_active_o to 0 at the next cycle.
- R6: A one-cycle pulse on btn_wake_i forces lp_active_o to 0 at the next cycle.
- R7: A one-cycle pulse on hrst_wake_i forces lp_active_o to 0 at the next cycle.
- R8: After an exit, holding both sleep_req_i and sleep_allow_i high does not re-enter. Re-entry follows either a low-then-high toggle of sleep_req_i or a low-then-high toggle of sleep_allow_i while sleep_req_i stays high.
- R9: If sleep_req_i and sleep_allow_i are both held high through reset and after it, this does not count as an entry edge.
- R10: An entry edge that coincides with a wake pulse leaves lp_active_o at 0.
- R11: While lp_active_o is 1, core_vsel_o equals vsel_lp_i.
- R12: core_off_o is 1 exactly when lp_active_o is 1 and core_off_cfg_i is 1.
- R13: In the first cycle after an exit, core_vsel_o equals the vsel_norm_i value sampled at the entry edge, even if vsel_norm_i changed during low-power mode. After that, core_vsel_o follows vsel_norm_i with one cycle of delay.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| sleep_req_i | input | 1 | Sleep request pin from the processor |
| sleep_allow_i | input | 1 | Configuration bit that allows sleep requests |
| core_off_cfg_i | input | 1 | Configuration bit: switch the core rail off in low-power mode |
| btn_wake_i | input | 1 | Debounced push-button wake pulse |
| hrst_wake_i | input | 1 | Debounced hot-reset wake pulse |
| vsel_norm_i | input | VSEL_W | Normal core voltage code |
| vsel_lp_i | input | VSEL_W | Low-power preset core voltage code |
| lp_active_o | output | 1 | Low-power mode is active |
| core_vsel_o | output | VSEL_W | Selected core voltage code |
| core_off_o | output | 1 | Core rail disable |

## Verification
The assertions check the exit conditions on every cycle:
- a low request, a low allow bit or a wake pulse is always followed by an inactive mode;
- every entry is preceded by a high gated request;
- the core-off output never appears outside the low-power mode.

Some behaviours depend on history across many cycles, so only the bench's scenarios show them:
- that re-entry needs a fresh toggle;
- that a level held high through reset is not an edge;
- that the voltage restored on exit is the one captured at entry.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int unsigned VSEL_W_DEF = 6;
  localparam int unsigned NUM_WAKE   = 2;

  typedef enum logic {
    LPM_AWAKE = 1'b0,
    LPM_SLEEP = 1'b1
  } lpm_state_e;
endpackage

// File: rtl/lpm_rst_sync.sv
module lpm_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/lpm_edge_det.sv
module lpm_edge_det (
  input  logic clk,
  input  logic rst_n,
  input  logic req_i,
  input  logic allow_i,
  output logic gate_o,
  output logic rise_o
);
  logic prev_q;
  logic prev_d;
  logic gate;

  assign gate = req_i & allow_i;

  always_comb begin
    prev_d = gate;
  end

  // Reset to 1: a level already high when reset ends is not an edge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= 1'b1;
    else        prev_q <= prev_d;
  end

  assign gate_o = gate;
  assign rise_o = gate & ~prev_q;
endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
  import lpm_pkg::*;
#(
  parameter int unsigned N_WAKE = NUM_WAKE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_i,
  input  logic              rise_i,
  input  logic [N_WAKE-1:0] wake_i,
  output logic              lp_o
);
  lpm_state_e state_q;
  lpm_state_e state_d;
  logic [N_WAKE:0] wake_or;
  logic exit_req;

  assign wake_or[0] = 1'b0;
  for (genvar g = 0; g < N_WAKE; g++) begin : g_wake
    assign wake_or[g+1] = wake_or[g] | wake_i[g];
  end

  assign exit_req = wake_or[N_WAKE] | ~gate_i;

  always_comb begin
    state_d = state_q;
    if (exit_req)    state_d = LPM_AWAKE;
    else if (rise_i) state_d = LPM_SLEEP;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LPM_AWAKE;
    else        state_q <= state_d;
  end

  assign lp_o = (state_q == LPM_SLEEP);
endmodule

// File: rtl/lpm_vsel_hold.sv
module lpm_vsel_hold #(
  parameter int unsigned VSEL_W = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              lp_i,
  input  logic              coff_cfg_i,
  input  logic [VSEL_W-1:0] norm_i,
  input  logic [VSEL_W-1:0] preset_i,
  output logic [VSEL_W-1:0] vsel_o,
  output logic              core_off_o
);
  logic [VSEL_W-1:0] held_q;
  logic [VSEL_W-1:0] held_d;
  logic              held_en;

  assign held_en = ~lp_i;

  always_comb begin
    held_d = held_q;
    if (held_en) held_d = norm_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) held_q <= '0;
    else        held_q <= held_d;
  end

  assign vsel_o     = lp_i ? preset_i : held_q;
  assign core_off_o = lp_i & coff_cfg_i;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int unsigned VSEL_W     = VSEL_W_DEF,
  parameter int unsigned RST_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sleep_req_i,
  input  logic              sleep_allow_i,
  input  logic              core_off_cfg_i,
  input  logic              btn_wake_i,
  input  logic              hrst_wake_i,
  input  logic [VSEL_W-1:0] vsel_norm_i,
  input  logic [VSEL_W-1:0] vsel_lp_i,
  output logic              lp_active_o,
  output logic [VSEL_W-1:0] core_vsel_o,
  output logic              core_off_o
);
  logic rst_int_n;
  logic gate;
  logic rise;
  logic lp;
  logic [NUM_WAKE-1:0] wake_vec;

  assign wake_vec = {hrst_wake_i, btn_wake_i};

  lpm_rst_sync #(.STAGES(RST_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_int_n)
  );

  lpm_edge_det u_edge (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .req_i   (sleep_req_i),
    .allow_i (sleep_allow_i),
    .gate_o  (gate),
    .rise_o  (rise)
  );

  lpm_mode_fsm #(.N_WAKE(NUM_WAKE)) u_fsm (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .gate_i (gate),
    .rise_i (rise),
    .wake_i (wake_vec),
    .lp_o   (lp)
  );

  lpm_vsel_hold #(.VSEL_W(VSEL_W)) u_vsel (
    .clk        (clk),
    .rst_n      (rst_int_n),
    .lp_i       (lp),
    .coff_cfg_i (core_off_cfg_i),
    .norm_i     (vsel_norm_i),
    .preset_i   (vsel_lp_i),
    .vsel_o     (core_vsel_o),
    .core_off_o (core_off_o)
  );

  assign lp_active_o = lp;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int unsigned VSEL_W = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              sleep_req_i,
  input logic              sleep_allow_i,
  input logic              core_off_cfg_i,
  input logic              btn_wake_i,
  input logic              hrst_wake_i,
  input logic [VSEL_W-1:0] vsel_norm_i,
  input logic [VSEL_W-1:0] vsel_lp_i,
  input logic              lp_active_o,
  input logic [VSEL_W-1:0] core_vsel_o,
  input logic              core_off_o
);
  a_r2_entry_needs_gate: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(lp_active_o) |-> $past(sleep_req_i && sleep_allow_i));

  a_r3_r5_allow_low_exits: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_allow_i |=> !lp_active_o);

  a_r4_req_low_exits: assert property (@(posedge clk) disable iff (!rst_n)
    !sleep_req_i |=> !lp_active_o);

  a_r6_r7_wake_exits: assert property (@(posedge clk) disable iff (!rst_n)
    (btn_wake_i || hrst_wake_i) |=> !lp_active_o);

  a_r12_core_off_only_sleeping: assert property (@(posedge clk) disable iff (!rst_n)
    core_off_o |-> (lp_active_o && core_off_cfg_i));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.VSEL_W(VSEL_W)) u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .sleep_req_i    (sleep_req_i),
  .sleep_allow_i  (sleep_allow_i),
  .core_off_cfg_i (core_off_cfg_i),
  .btn_wake_i     (btn_wake_i),
  .hrst_wake_i    (hrst_wake_i),
  .vsel_norm_i    (vsel_norm_i),
  .vsel_lp_i      (vsel_lp_i),
  .lp_active_o    (lp_active_o),
  .core_vsel_o    (core_vsel_o),
  .core_off_o     (core_off_o)
);

// File: tb/tb_lpm_ctrl.sv
module tb_lpm_ctrl;
  localparam int VW = 6;
  localparam logic [VW-1:0] V_NORM = 6'h20;
  localparam logic [VW-1:0] V_LOW  = 6'h0A;
  localparam logic [VW-1:0] V_NEW  = 6'h33;

  logic clk = 1'b0;
  logic rst_n;
  logic req, allow, coff, btn, hrst;
  logic [VW-1:0] vnorm, vlow;
  logic lp, off;
  logic [VW-1:0] vsel;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  lpm_ctrl #(.VSEL_W(VW)) dut (
    .clk            (clk),
    .rst_n          (rst_n),
    .sleep_req_i    (req),
    .sleep_allow_i  (allow),
    .core_off_cfg_i (coff),
    .btn_wake_i     (btn),
    .hrst_wake_i    (hrst),
    .vsel_norm_i    (vnorm),
    .vsel_lp_i      (vlow),
    .lp_active_o    (lp),
    .core_vsel_o    (vsel),
    .core_off_o     (off)
  );

  // vector: {req, allow, btn, hrst, coff, exp_lp, exp_off}
  localparam int NV = 22;
  localparam logic [6:0] VEC [NV] = '{
    7'b01000_00, // 0  R1 idle, allow set
    7'b11000_10, // 1  R2 entry edge
    7'b11000_10, // 2  R2 stays
    7'b01000_00, // 3  R4 req low exits
    7'b11000_10, // 4  R2 re-entry by req toggle
    7'b10000_00, // 5  R5 allow cleared exits
    7'b11000_10, // 6  R8 allow toggle with req high re-enters
    7'b11100_00, // 7  R6 button wake
    7'b11000_00, // 8  R8 no re-entry without toggle
    7'b01000_00, // 9  R8 req low
    7'b11000_10, // 10 R8 req toggle re-enters
    7'b11010_00, // 11 R7 hot-reset wake
    7'b11000_00, // 12 R8 no re-entry
    7'b00000_00, // 13
    7'b10000_00, // 14 R3 req ignored
    7'b00000_00, // 15 R3
    7'b10000_00, // 16 R3
    7'b11000_10, // 17 R2 allow rises with req high
    7'b11001_11, // 18 R12 core off in sleep
    7'b01001_00, // 19 R12 core off cleared on exit
    7'b11100_00, // 20 R10 edge with wake: wake wins
    7'b11000_00  // 21 R10 no late entry
  };

  task automatic chk(input string req_tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at %0t", req_tag, act, exp, $time);
    end
  endtask

  task automatic tick;
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic do_reset(input logic r, input logic a);
    rst_n = 1'b0;
    req = r; allow = a; coff = 1'b0; btn = 1'b0; hrst = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) tick();
  endtask

  initial begin
    vnorm = V_NORM;
    vlow  = V_LOW;
    do_reset(1'b0, 1'b0);
    chk("R1 lp", int'(lp), 0);
    chk("R1 off", int'(off), 0);
    chk("R1 vsel", int'(vsel), int'(V_NORM));

    for (int i = 0; i < NV; i++) begin
      {req, allow, btn, hrst, coff} = VEC[i][6:2];
      tick();
      btn = 1'b0; hrst = 1'b0;
      chk($sformatf("vec%0d lp", i), int'(lp), int'(VEC[i][1]));
      chk($sformatf("vec%0d off R12", i), int'(off), int'(VEC[i][0]));
      chk($sformatf("vec%0d vsel R11", i), int'(vsel),
          VEC[i][1] ? int'(V_LOW) : int'(V_NORM));
    end

    // R9: gated level held high through reset is not an edge
    do_reset(1'b1, 1'b1);
    chk("R9 lp after reset", int'(lp), 0);
    repeat (3) tick();
    chk("R9 still awake", int'(lp), 0);

    // R13: value at entry restored on exit
    req = 1'b0; tick();
    req = 1'b1; tick();
    chk("R13 entered", int'(lp), 1);
    vnorm = V_NEW; tick();
    chk("R11 preset while sleeping", int'(vsel), int'(V_LOW));
    req = 1'b0; tick();
    chk("R13 lp exit", int'(lp), 0);
    chk("R13 restored", int'(vsel), int'(V_NORM));
    tick();
    chk("R13 follows new", int'(vsel), int'(V_NEW));

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule